// File: doc/BRIEF.md
# System Control Register Bank

A block of 512 general-purpose 32-bit words reached over a simple word-addressed bus inside a 4 KiB window. Software stores words and reads them back. Three words report status: when they are read, two upper bits are forced high. One address near the top of the window is a command port. Writing certain values there asks the rest of the chip for a system reset or a shutdown. Any access outside the storage range is flagged.

Each bus transfer lasts one cycle (valid, write, address, data). Read data and the access-error flag are registered and appear one clock after the strobe. The request outputs are one-cycle pulses in that same following cycle. The block only raises the requests; the rest of the chip carries out reset and power sequencing.

Top module: `sysctl_bank`

## Requirements
- R1: After reset, word 0x40 holds 0x05F20121, word 0x41 holds 0x00000002, word 0x42 holds 0x05F30121, word 0x43 holds 0x05F40121, and every other word holds zero.
- R2: A write with word index (address bits [11:2]) below 512 stores the data. A read of that word returns it on `bus_rdata` in the cycle after the read strobe.
- R3: Address bits [1:0] play no part in selecting a word.
- R4: A read of word 0x40, 0x42 or 0x43 (byte offsets 0x100, 0x108, 0x10C) returns the stored word OR 0x30000000. The stored word is left unchanged. No other word is altered on read.
- R5: A write with word index 512 or above changes no stored word, including the word that its low nine index bits would name. `access_err` is high for one cycle in the cycle after the write.
- R6: A read with word index 512 or above returns zero on `bus_rdata`, with `access_err` high in the cycle after the strobe.
- R7: A write of 1 or 2 to byte offset 0xF00 pulses `reset_req` for one cycle in the cycle after the write.
- R8: A write of 3 to byte offset 0xF00 pulses `shutdown_req` for one cycle in the cycle after the write. `reset_req` and `shutdown_req` are never high together.
- R9: A write of any other value to 0xF00 raises no request. Every write to 0xF00, including a command, is out of range: it is flagged by `access_err` and is not stored.
- R10: With no strobe, `access_err`, `reset_req` and `shutdown_req` are low in the next cycle. `bus_rdata` changes only in the cycle after a read strobe and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Transfer strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| access_err | output | 1 | Pulse: previous access was outside storage |
| reset_req | output | 1 | Pulse: system reset requested |
| shutdown_req | output | 1 | Pulse: shutdown requested |

## Verification
The bench writes the whole store with a computed pattern and reads it back at every low-address offset. A bank that decodes bits [1:0], or that forces the status bits on the wrong words, shows up as data miscompares. It then sweeps every out-of-range index, first with writes and then with reads. A design that wraps the index back into storage would corrupt the aliased word, and a design that passes stale data on error would return nonzero. The command port gets a set of values around 1 to 3. This catches a wrong value decode, a missing error flag at 0xF00, a command wrongly stored into the aliased word, and a pulse that stays high for more than one cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int CMD_BYTE = 'hF00;
  localparam logic [31:0] STATUS_MASK = 32'h3000_0000;

  typedef enum logic [1:0] {REQ_NONE, REQ_RESET, REQ_SHUT} req_e;

  function automatic req_e decode_cmd(input logic [31:0] v);
    if (v == 32'd1 || v == 32'd2) return REQ_RESET;
    if (v == 32'd3)               return REQ_SHUT;
    return REQ_NONE;
  endfunction

  function automatic logic [31:0] reset_word(input int i);
    case (i)
      'h40:    return 32'h05F2_0121;
      'h41:    return 32'h0000_0002;
      'h42:    return 32'h05F3_0121;
      'h43:    return 32'h05F4_0121;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic is_status(input int i);
    return (i == 'h40) || (i == 'h42) || (i == 'h43);
  endfunction
endpackage

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_hit,
  input  logic [DATA_W-1:0] cmd_val,
  output logic              reset_req,
  output logic              shutdown_req
);
  req_e kind;
  assign kind = decode_cmd(32'(cmd_val));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_req    <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      reset_req    <= cmd_hit && (kind == REQ_RESET);
      shutdown_req <= cmd_hit && (kind == REQ_SHUT);
    end
  end

  p_req_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reset_req && shutdown_req));
  p_reset_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(cmd_hit) && ($past(cmd_val) == 1 || $past(cmd_val) == 2));
  p_shut_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(cmd_hit) && $past(cmd_val) == 3);
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int NWORDS = 512,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [$clog2(NWORDS)-1:0] idx,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata
);
  localparam int SW = $clog2(NWORDS);

  logic [DATA_W-1:0] mem [NWORDS];
  logic              status_rd;
  logic [DATA_W-1:0] rd_word;

  assign status_rd = is_status(int'(idx));
  assign rd_word   = status_rd ? (mem[idx] | DATA_W'(STATUS_MASK)) : mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= DATA_W'(reset_word(i));
    end else if (wr_en) begin
      mem[idx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  p_status_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && status_rd |=> rdata[29:28] == 2'b11);
  p_rd_matches_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !status_rd |=> rdata == $past(mem[idx]));
  p_no_dual_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));
  logic unused_sw;
  assign unused_sw = (SW == 0);
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NWORDS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              access_err,
  output logic              reset_req,
  output logic              shutdown_req
);
  localparam int IDX_W   = ADDR_W - 2;
  localparam int SW      = $clog2(NWORDS);
  localparam int CMD_IDX = CMD_BYTE / 4;

  logic [IDX_W-1:0] word_idx;
  logic             in_rng;
  logic             cmd_hit;
  logic             st_wr;
  logic             st_rd;
  logic             oor_rd;
  logic [DATA_W-1:0] st_rdata;
  logic             oor_rd_q;
  logic             unused_lo;

  assign word_idx  = bus_addr[ADDR_W-1:2];
  assign unused_lo = ^bus_addr[1:0];
  assign in_rng    = int'(word_idx) < NWORDS;
  assign cmd_hit   = bus_valid && bus_write && (int'(word_idx) == CMD_IDX);
  assign st_wr     = bus_valid && bus_write && in_rng;
  assign st_rd     = bus_valid && !bus_write && in_rng;
  assign oor_rd    = bus_valid && !bus_write && !in_rng;

  sysctl_cmd #(.DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_hit(cmd_hit), .cmd_val(bus_wdata),
    .reset_req(reset_req), .shutdown_req(shutdown_req)
  );

  sysctl_store #(.NWORDS(NWORDS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(st_wr), .rd_en(st_rd),
    .idx(word_idx[SW-1:0]), .wdata(bus_wdata), .rdata(st_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      access_err <= 1'b0;
      oor_rd_q   <= 1'b0;
    end else begin
      access_err <= bus_valid && !in_rng;
      if (bus_valid && !bus_write) oor_rd_q <= oor_rd;
    end
  end

  assign bus_rdata = oor_rd_q ? '0 : st_rdata;

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    access_err |-> $past(bus_valid) && int'($past(word_idx)) >= NWORDS);
  p_oor_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oor_rd) |-> bus_rdata == '0 && access_err);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_valid) |-> !access_err && !reset_req && !shutdown_req);
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_valid && !bus_write) |-> $stable(bus_rdata));
  p_cmd_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> access_err);
endmodule

// File: tb/test_sysctl_bank.sv
module test_sysctl_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        access_err, reset_req, shutdown_req;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  sysctl_bank i_sysctl_bank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .access_err(access_err), .reset_req(reset_req), .shutdown_req(shutdown_req)
  );

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] init_val(input int i);
    if (i == 64) return 32'h05F2_0121;
    if (i == 65) return 32'h0000_0002;
    if (i == 66) return 32'h05F3_0121;
    if (i == 67) return 32'h05F4_0121;
    return 32'h0;
  endfunction

  function automatic logic [31:0] seen(input int i, input logic [31:0] v);
    if (i == 64 || i == 66 || i == 67) return v | 32'h3000_0000;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // R10: reset state of the outputs
    check("R10 rdata after reset", bus_rdata, 32'h0);
    check("R10 err after reset", {31'b0, access_err}, 32'h0);
    check("R10 req after reset", {30'b0, reset_req, shutdown_req}, 32'h0);

    // R1, R3, R4: reset contents, low address bits varied
    for (int i = 0; i < 512; i++) begin
      access(1'b0, 12'(i * 4 + (i % 4)), 32'h0);
      check("R1 reset word", bus_rdata, seen(i, init_val(i)));
      check("R3 no err in range", {31'b0, access_err}, 32'h0);
    end

    // R2: write the pattern everywhere, then read it back
    for (int i = 0; i < 512; i++) begin
      access(1'b1, 12'(i * 4 + ((i + 1) % 4)), pat(i));
      check("R2 write no err", {29'b0, access_err, reset_req, shutdown_req}, 32'h0);
    end
    for (int i = 0; i < 512; i++) begin
      access(1'b0, 12'(i * 4 + ((i + 2) % 4)), 32'h0);
      check("R2/R3/R4 readback", bus_rdata, seen(i, pat(i)));
    end

    // R4: status word with zero stored reads only the forced bits
    access(1'b1, 12'h100, 32'h0);
    access(1'b0, 12'h100, 32'h0);
    check("R4 forced bits only", bus_rdata, 32'h3000_0000);
    access(1'b1, 12'h104, 32'h0);
    access(1'b0, 12'h104, 32'h0);
    check("R4 word 0x41 not forced", bus_rdata, 32'h0);
    access(1'b1, 12'h100, pat(64));
    access(1'b1, 12'h104, pat(65));

    // R5: out-of-range writes flagged and dropped
    for (int i = 512; i < 1024; i++) begin
      if (i != 960) begin
        access(1'b1, 12'(i * 4), ~pat(i - 512));
        check("R5 write err", {31'b0, access_err}, 32'h1);
      end
    end
    for (int i = 0; i < 512; i++) begin
      access(1'b0, 12'(i * 4), 32'h0);
      check("R5 store untouched", bus_rdata, seen(i, pat(i)));
    end

    // R6: out-of-range reads return zero with error
    for (int i = 512; i < 1024; i++) begin
      access(1'b0, 12'(i * 4 + (i % 4)), 32'h0);
      check("R6 read zero", bus_rdata, 32'h0);
      check("R6 read err", {31'b0, access_err}, 32'h1);
    end

    // R7, R8, R9: command port values
    for (int v = 0; v < 8; v++) begin
      logic [31:0] val;
      val = (v < 6) ? 32'(v) : ((v == 6) ? 32'hFFFF_FFFF : 32'h0000_0101);
      access(1'b1, 12'hF00, val);
      check("R7 reset pulse", {31'b0, reset_req}, {31'b0, (val == 1 || val == 2)});
      check("R8 shutdown pulse", {31'b0, shutdown_req}, {31'b0, (val == 3)});
      check("R9 cmd flagged", {31'b0, access_err}, 32'h1);
      idle();
      check("R10 pulses end", {29'b0, access_err, reset_req, shutdown_req}, 32'h0);
    end
    access(1'b0, 12'h700, 32'h0);
    check("R9 command not stored", bus_rdata, pat(448));

    // R10: rdata holds across a write and idle cycles
    access(1'b0, 12'h014, 32'h0);
    held = bus_rdata;
    check("R2 read word 5", held, pat(5));
    access(1'b1, 12'h018, 32'hDEAD_BEEF);
    idle();
    check("R10 rdata held", bus_rdata, held);
    access(1'b0, 12'h018, 32'h0);
    check("R2 latest write", bus_rdata, 32'hDEAD_BEEF);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule